// File: doc/BRIEF.md
# Sector Buffer DMA Transfer Engine

This engine moves bytes between a 256-byte sector buffer and system memory through a byte-wide DMA master port. A controller sequencer starts it with a one-cycle pulse after it has collected a word count, a 16-bit bus address with two extension bits, the operation and the density. Three operations are served. A fill loads the buffer from memory. An empty stores the buffer to memory. An extended-status dump writes an 8-byte record built from controller and drive state.

Before a fill or an empty, the word count is checked against the sector size for the selected density. An oversize request ends at once with an overflow flag and no memory traffic. A fill always zeroes the whole buffer before it copies anything in. One byte moves on each memory handshake. A memory fault stops the run immediately and reports how many words were left unmoved. The engine holds `busy` from the start pulse until the single cycle in which it raises `done`.

Top module: `secbuf_dma_engine`

## Requirements
- R1: For a fill (op 2'b00) or an empty (op 2'b01), a word count whose double exceeds the sector size ends the command with `wco_err`=1 and `err_code`=8'h98 (octal 230). The sector size is 128 bytes when `dbl_den`=0 and 256 bytes when `dbl_den`=1. No memory request is made, the buffer is not written, and `wc_left` equals the word count.
- R2: A fill first writes zero to all 256 buffer bytes. It then reads 2×`wc_in` bytes from memory and stores byte i at buffer address i. Bytes past that length stay zero.
- R3: An empty writes buffer bytes 0 to 2×`wc_in`−1 to memory in order and writes no other memory byte.
- R4: Byte i of a transfer goes to or comes from address {`ext_in`,`ba_in`}+i. Each accepted request is followed either by the request for the next address or by no request.
- R5: A request answered by `mem_err` sets `nxm_err` and ends the command with no further request. For a fill or an empty, `wc_left` becomes (n−i)/2 rounded down, where n is the byte length and i is the index of the faulting byte.
- R6: A fill or an empty that completes without a fault ends with `wc_left`=0, `nxm_err`=0, `wco_err`=0 and `err_code`=0.
- R7: The extended-status operation (op 2'b10) writes 8 bytes in this order: error code, word count, drive 0 track, drive 1 track, requested track, requested sector, flag byte, and the track of the selected drive. The selected drive is drive 1 when `xs_drv_sel`=1. It does no overflow check and leaves `wc_left` equal to the word count, even after a fault.
- R8: In the flag byte, bit 7 is `xs_drv_sel`, bit 6 is `xs_d1_dbl`, bit 5 is `xs_sel_ready`, bit 4 is `xs_d0_dbl` and bit 0 is the command density. Bits 3 to 1 are zero.
- R9: `busy` rises the cycle after an accepted start and stays high through the single `done` cycle, then falls. A start pulse while busy has no effect.
- R10: Op 2'b11 completes with `done`, no memory request and no error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command start |
| op | input | 2 | 00 fill, 01 empty, 10 status dump, 11 no transfer |
| dbl_den | input | 1 | Command density, 1 selects 256-byte sectors |
| wc_in | input | 8 | Word count |
| ba_in | input | 16 | Bus address low part |
| ext_in | input | 2 | Bus address extension bits |
| xs_ecode | input | 8 | Error code for the status record |
| xs_trk0 | input | 8 | Drive 0 current track |
| xs_trk1 | input | 8 | Drive 1 current track |
| xs_req_trk | input | 8 | Requested track |
| xs_req_sec | input | 8 | Requested sector |
| xs_drv_sel | input | 1 | Selected drive |
| xs_d0_dbl | input | 1 | Drive 0 holds double-density media |
| xs_d1_dbl | input | 1 | Drive 1 holds double-density media |
| xs_sel_ready | input | 1 | Selected drive has media attached |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed in this cycle |
| mem_err | input | 1 | Request failed in this cycle |
| buf_addr | output | 8 | Sector buffer address |
| buf_we | output | 1 | Sector buffer write enable |
| buf_wdata | output | 8 | Sector buffer write data |
| buf_rdata | input | 8 | Sector buffer read data at `buf_addr` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion |
| wco_err | output | 1 | Word count overflow on the last command |
| nxm_err | output | 1 | Memory fault on the last command |
| err_code | output | 8 | Error code of the last command |
| wc_left | output | 8 | Residual word count of the last command |

## Verification
The hardest case to reach is a fault in the middle of a fill. In that case the buffer holds a copied prefix, then zeros from the clearing pass, and the residual count depends on the exact faulting index. The bench memory model answers `mem_err` for one chosen address. Placing that address at the first, a middle and the last byte of fills, empties and status dumps forces the engine into those partial states, and the buffer, memory and residual count are then compared byte by byte. A second start pulse is injected partway through a fill to show that it has no effect.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

    typedef enum logic [1:0] {
        OP_FILL  = 2'b00,
        OP_EMPTY = 2'b01,
        OP_XSTAT = 2'b10,
        OP_NONE  = 2'b11
    } dma_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_MOVE,
        ST_FINISH
    } eng_state_e;

    localparam int BUF_BYTES  = 256;
    localparam int BUF_AW     = 8;
    localparam int SD_BYTES   = 128;
    localparam int XREC_BYTES = 8;
    localparam logic [7:0] ECODE_WCO = 8'o230;

    typedef struct packed {
        logic [7:0] ecode;
        logic [7:0] wc;
        logic [7:0] trk0;
        logic [7:0] trk1;
        logic [7:0] req_trk;
        logic [7:0] req_sec;
        logic       drv_sel;
        logic       d1_dbl;
        logic       sel_ready;
        logic       d0_dbl;
        logic       cmd_dbl;
    } xstat_src_t;

    function automatic logic [BUF_AW:0] sector_bytes(input logic dbl);
        return dbl ? (BUF_AW+1)'(BUF_BYTES) : (BUF_AW+1)'(SD_BYTES);
    endfunction

endpackage

// File: rtl/dmaeng_wc_check.sv
module dmaeng_wc_check
    import dmaeng_pkg::*;
(
    input  dma_op_e          op,
    input  logic             dbl,
    input  logic [7:0]       wc,
    output logic             overflow,
    output logic [BUF_AW:0]  nbytes
);
    logic [BUF_AW:0] twice_wc;

    always_comb begin
        twice_wc = {wc, 1'b0};
        overflow = 1'b0;
        unique case (op)
            OP_FILL, OP_EMPTY: begin
                nbytes   = twice_wc;
                overflow = (twice_wc > sector_bytes(dbl));
            end
            OP_XSTAT: nbytes = (BUF_AW+1)'(XREC_BYTES);
            default:  nbytes = '0;
        endcase
    end
endmodule

// File: rtl/dmaeng_xstat_rec.sv
module dmaeng_xstat_rec
    import dmaeng_pkg::*;
(
    input  xstat_src_t  src,
    input  logic [2:0]  idx,
    output logic [7:0]  data
);
    logic [7:0] flags;
    logic [7:0] sel_trk;

    always_comb begin
        flags   = {src.drv_sel, src.d1_dbl, src.sel_ready, src.d0_dbl, 3'b000, src.cmd_dbl};
        sel_trk = src.drv_sel ? src.trk1 : src.trk0;
        unique case (idx)
            3'd0: data = src.ecode;
            3'd1: data = src.wc;
            3'd2: data = src.trk0;
            3'd3: data = src.trk1;
            3'd4: data = src.req_trk;
            3'd5: data = src.req_sec;
            3'd6: data = flags;
            default: data = sel_trk;
        endcase
    end
endmodule

// File: rtl/secbuf_dma_engine.sv
module secbuf_dma_engine
    import dmaeng_pkg::*;
#(
    parameter int BA_W  = 16,
    parameter int EXT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [1:0]              op,
    input  logic                    dbl_den,
    input  logic [7:0]              wc_in,
    input  logic [BA_W-1:0]         ba_in,
    input  logic [EXT_W-1:0]        ext_in,
    input  logic [7:0]              xs_ecode,
    input  logic [7:0]              xs_trk0,
    input  logic [7:0]              xs_trk1,
    input  logic [7:0]              xs_req_trk,
    input  logic [7:0]              xs_req_sec,
    input  logic                    xs_drv_sel,
    input  logic                    xs_d0_dbl,
    input  logic                    xs_d1_dbl,
    input  logic                    xs_sel_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [BA_W+EXT_W-1:0]   mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    input  logic                    mem_ack,
    input  logic                    mem_err,
    output logic [BUF_AW-1:0]       buf_addr,
    output logic                    buf_we,
    output logic [7:0]              buf_wdata,
    input  logic [7:0]              buf_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    wco_err,
    output logic                    nxm_err,
    output logic [7:0]              err_code,
    output logic [7:0]              wc_left
);
    localparam int ADDR_W = BA_W + EXT_W;
    localparam int IDX_W  = BUF_AW + 1;

    eng_state_e       state_q;
    dma_op_e          op_q;
    logic             dbl_q;
    logic [ADDR_W-1:0] base_q;
    logic [7:0]       wc_q;
    logic [IDX_W-1:0] nbytes_q;
    logic [IDX_W-1:0] idx_q;
    logic             wco_q, nxm_q;
    logic [7:0]       ecode_q, left_q;

    logic             ovf_w;
    logic [IDX_W-1:0] nbytes_w;
    logic [7:0]       rec_byte;
    logic             more;
    logic [IDX_W-1:0] remain;
    xstat_src_t       xsrc;

    dmaeng_wc_check u_chk (
        .op       (dma_op_e'(op)),
        .dbl      (dbl_den),
        .wc       (wc_in),
        .overflow (ovf_w),
        .nbytes   (nbytes_w)
    );

    always_comb begin
        xsrc = '{ecode: xs_ecode, wc: wc_q, trk0: xs_trk0, trk1: xs_trk1,
                 req_trk: xs_req_trk, req_sec: xs_req_sec, drv_sel: xs_drv_sel,
                 d1_dbl: xs_d1_dbl, sel_ready: xs_sel_ready, d0_dbl: xs_d0_dbl,
                 cmd_dbl: dbl_q};
    end

    dmaeng_xstat_rec u_rec (
        .src  (xsrc),
        .idx  (idx_q[2:0]),
        .data (rec_byte)
    );

    assign more   = (idx_q != nbytes_q);
    assign remain = nbytes_q - idx_q;

    // Datapath outputs for the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = (op_q != OP_FILL);
        mem_addr  = base_q + ADDR_W'(idx_q);
        mem_wdata = (op_q == OP_XSTAT) ? rec_byte : buf_rdata;
        buf_addr  = idx_q[BUF_AW-1:0];
        buf_we    = 1'b0;
        buf_wdata = 8'h00;
        unique case (state_q)
            ST_CLEAR: buf_we = 1'b1;
            ST_MOVE: begin
                mem_req = more;
                if (more && op_q == OP_FILL && mem_ack && !mem_err) begin
                    buf_we    = 1'b1;
                    buf_wdata = mem_rdata;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_NONE;
            dbl_q    <= 1'b0;
            base_q   <= '0;
            wc_q     <= '0;
            nbytes_q <= '0;
            idx_q    <= '0;
            wco_q    <= 1'b0;
            nxm_q    <= 1'b0;
            ecode_q  <= '0;
            left_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q     <= dma_op_e'(op);
                    dbl_q    <= dbl_den;
                    base_q   <= {ext_in, ba_in};
                    wc_q     <= wc_in;
                    nbytes_q <= nbytes_w;
                    idx_q    <= '0;
                    nxm_q    <= 1'b0;
                    wco_q    <= ovf_w;
                    ecode_q  <= ovf_w ? ECODE_WCO : 8'h00;
                    left_q   <= wc_in;
                    if (ovf_w)
                        state_q <= ST_FINISH;
                    else if (dma_op_e'(op) == OP_FILL)
                        state_q <= ST_CLEAR;
                    else
                        state_q <= ST_MOVE;
                end
                ST_CLEAR: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(BUF_BYTES - 1)) begin
                        idx_q   <= '0;
                        state_q <= ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (!more) begin
                        left_q  <= (op_q == OP_XSTAT) ? wc_q : 8'h00;
                        state_q <= ST_FINISH;
                    end else if (mem_err) begin
                        nxm_q   <= 1'b1;
                        left_q  <= (op_q == OP_XSTAT) ? wc_q : remain[IDX_W-1:1];
                        state_q <= ST_FINISH;
                    end else if (mem_ack) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_FINISH);
    assign wco_err  = wco_q;
    assign nxm_err  = nxm_q;
    assign err_code = ecode_q;
    assign wc_left  = left_q;

    a_r1_no_dma_on_overflow: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ovf_w) |=> (done && !mem_req));

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        done |-> !(wco_err && nxm_err));

    a_r2_buf_only_on_fill: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> !mem_we);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_err) |=> (!mem_req || mem_addr == $past(mem_addr) + 1'b1));

    a_r5_fault_stop: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err) |=> (done && nxm_err && !mem_req));

    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: tb/sim_secbuf_dma_engine.sv
module sim_secbuf_dma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b11;
    logic        dbl_den = 1'b0;
    logic [7:0]  wc_in = '0;
    logic [15:0] ba_in = '0;
    logic [1:0]  ext_in = '0;
    logic [7:0]  xs_ecode = '0, xs_trk0 = '0, xs_trk1 = '0, xs_req_trk = '0, xs_req_sec = '0;
    logic        xs_drv_sel = 0, xs_d0_dbl = 0, xs_d1_dbl = 0, xs_sel_ready = 0;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [17:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  buf_addr, buf_wdata, buf_rdata;
    logic        buf_we, busy, done, wco_err, nxm_err;
    logic [7:0]  err_code, wc_left;

    logic [7:0]  mem [0:1023];
    logic [7:0]  bufm [0:255];
    logic        fault_en = 1'b0;
    logic [17:0] fault_addr = '0;
    logic [17:0] exp_base = '0;
    int nreq, addr_bad, vectors, fails;
    logic r_wco, r_nxm;
    logic [7:0] r_code, r_left;

    always #5 clk = ~clk;

    secbuf_dma_engine u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .dbl_den(dbl_den),
        .wc_in(wc_in), .ba_in(ba_in), .ext_in(ext_in),
        .xs_ecode(xs_ecode), .xs_trk0(xs_trk0), .xs_trk1(xs_trk1),
        .xs_req_trk(xs_req_trk), .xs_req_sec(xs_req_sec), .xs_drv_sel(xs_drv_sel),
        .xs_d0_dbl(xs_d0_dbl), .xs_d1_dbl(xs_d1_dbl), .xs_sel_ready(xs_sel_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .wco_err(wco_err), .nxm_err(nxm_err),
        .err_code(err_code), .wc_left(wc_left)
    );

    assign mem_err   = mem_req && fault_en && (mem_addr == fault_addr);
    assign mem_ack   = mem_req && !mem_err;
    assign mem_rdata = mem[mem_addr[9:0]];
    assign buf_rdata = bufm[buf_addr];

    // Memory and buffer models act mid-cycle, away from the active edge
    always @(negedge clk) begin
        if (mem_req) begin
            if (mem_addr != exp_base + 18'(nreq)) addr_bad++;
            nreq++;
            if (mem_we && mem_ack) mem[mem_addr[9:0]] = mem_wdata;
        end
        if (buf_we) bufm[buf_addr] = buf_wdata;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + (a >> 8) * 11 + 5);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        for (int i = 0; i < 256; i++) bufm[i] = 8'hFF;
    endtask

    task automatic run(input logic [1:0] o, input logic d, input logic [7:0] w,
                       input logic [17:0] base, input bit poke);
        int t;
        @(negedge clk);
        op = o; dbl_den = d; wc_in = w; {ext_in, ba_in} = base;
        exp_base = base; nreq = 0; addr_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            op = 2'b11; wc_in = 8'd0; ba_in = 16'h0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk("R9 done reached", int'(done), 1);
        r_wco = wco_err; r_nxm = nxm_err; r_code = err_code; r_left = wc_left;
        chk("R9 busy in done cycle", int'(busy), 1);
        @(negedge clk);
        chk("R9 busy drops", int'(busy), 0);
    endtask

    task automatic fill_test(input logic d, input logic [7:0] w, input logic [17:0] base, input bit poke);
        int bad;
        int n;
        n = 2 * w;
        preload();
        fault_en = 1'b0;
        run(2'b00, d, w, base, poke);
        chk("R6 fill wco", int'(r_wco), 0);
        chk("R6 fill nxm", int'(r_nxm), 0);
        chk("R6 fill residual", int'(r_left), 0);
        chk("R6 fill code", int'(r_code), 0);
        chk("R2 fill request count", nreq, n);
        chk("R4 fill addresses", addr_bad, 0);
        bad = 0;
        for (int i = 0; i < 256; i++)
            if (bufm[i] != ((i < n) ? pat(int'((base + 18'(i)) & 18'h3FF)) : 8'h00)) bad++;
        chk("R2 fill buffer image", bad, 0);
    endtask

    task automatic empty_test(input logic d, input logic [7:0] w, input logic [17:0] base);
        int bad;
        int n;
        int a;
        n = 2 * w;
        preload();
        for (int i = 0; i < 256; i++) bufm[i] = pat(i + 77);
        fault_en = 1'b0;
        run(2'b01, d, w, base, 1'b0);
        chk("R6 empty nxm", int'(r_nxm), 0);
        chk("R6 empty residual", int'(r_left), 0);
        chk("R3 empty request count", nreq, n);
        chk("R4 empty addresses", addr_bad, 0);
        bad = 0;
        for (int i = 0; i <= n; i++) begin
            a = int'((base + 18'(i)) & 18'h3FF);
            if (mem[a] != ((i < n) ? pat(i + 77) : pat(a))) bad++;
        end
        chk("R3 empty memory image", bad, 0);
    endtask

    task automatic xstat_test(input logic sel, input logic [17:0] base);
        logic [7:0] exp [0:7];
        int bad;
        int a;
        preload();
        fault_en = 1'b0;
        xs_ecode = 8'o070; xs_trk0 = 8'd12; xs_trk1 = 8'd61;
        xs_req_trk = 8'd33; xs_req_sec = 8'd19; xs_drv_sel = sel;
        xs_d0_dbl = ~sel; xs_d1_dbl = 1'b1; xs_sel_ready = sel;
        exp[0] = 8'o070; exp[1] = 8'd150; exp[2] = 8'd12; exp[3] = 8'd61;
        exp[4] = 8'd33; exp[5] = 8'd19;
        exp[6] = {sel, 1'b1, sel, ~sel, 3'b000, 1'b1};
        exp[7] = sel ? 8'd61 : 8'd12;
        run(2'b10, 1'b1, 8'd150, base, 1'b0);
        chk("R7 status no overflow", int'(r_wco), 0);
        chk("R7 status wc kept", int'(r_left), 150);
        chk("R7 status request count", nreq, 8);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            a = int'((base + 18'(i)) & 18'h3FF);
            if (i == 6) chk("R8 flag byte", int'(mem[a]), int'(exp[6]));
            else if (mem[a] != exp[i]) bad++;
        end
        chk("R7 record bytes", bad, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        vectors = 0; fails = 0; nreq = 0; addr_bad = 0;
        preload();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R4 reset no request", int'(mem_req), 0);
        chk("R1 reset flags", int'(wco_err | nxm_err), 0);

        // Fills across densities, lengths and extension bits
        fill_test(1'b0, 8'd0,   18'h0_0123, 1'b0);
        fill_test(1'b0, 8'd1,   18'h1_0200, 1'b0);
        fill_test(1'b0, 8'd7,   18'h2_03F8, 1'b0);
        fill_test(1'b0, 8'd64,  18'h3_0010, 1'b0);
        fill_test(1'b1, 8'd100, 18'h2_FF40, 1'b0);
        fill_test(1'b1, 8'd128, 18'h1_0100, 1'b0);
        // R9 start pulse while busy ignored
        fill_test(1'b1, 8'd20,  18'h0_0300, 1'b1);

        // Empties
        empty_test(1'b0, 8'd1,   18'h0_0040);
        empty_test(1'b0, 8'd64,  18'h3_0280);
        empty_test(1'b1, 8'd128, 18'h2_0001);
        empty_test(1'b1, 8'd33,  18'h1_FFF0);

        // R1 overflow cases
        preload();
        run(2'b00, 1'b0, 8'd65, 18'h0_0100, 1'b0);
        chk("R1 fill sd overflow flag", int'(r_wco), 1);
        chk("R1 overflow code", int'(r_code), 8'h98);
        chk("R1 overflow residual", int'(r_left), 65);
        chk("R1 overflow no request", nreq, 0);
        chk("R1 buffer untouched", int'(bufm[0]), 8'hFF);
        run(2'b00, 1'b1, 8'd129, 18'h0_0100, 1'b0);
        chk("R1 fill dd overflow flag", int'(r_wco), 1);
        chk("R1 dd no request", nreq, 0);
        chk("R1 buffer untouched dd", int'(bufm[200]), 8'hFF);
        run(2'b01, 1'b0, 8'd255, 18'h0_0100, 1'b0);
        chk("R1 empty overflow flag", int'(r_wco), 1);
        chk("R1 empty overflow residual", int'(r_left), 255);
        chk("R1 empty no request", nreq, 0);

        // R5 faults
        preload();
        fault_en = 1'b1; fault_addr = 18'h1_0107;
        run(2'b00, 1'b1, 8'd10, 18'h1_0100, 1'b0);
        chk("R5 fill fault nxm", int'(r_nxm), 1);
        chk("R5 fill fault residual", int'(r_left), 6);
        chk("R5 fill fault stop", nreq, 8);
        chk("R5 fill prefix copied", int'(bufm[6]), int'(pat(32'h106)));
        chk("R5 fill rest zero", int'(bufm[7]), 0);
        preload();
        fault_en = 1'b1; fault_addr = 18'h2_0050;
        run(2'b01, 1'b0, 8'd3, 18'h2_0050, 1'b0);
        chk("R5 empty first-byte residual", int'(r_left), 3);
        chk("R5 empty first-byte stop", nreq, 1);
        preload();
        fault_en = 1'b1; fault_addr = 18'h0_0087;
        run(2'b01, 1'b0, 8'd4, 18'h0_0080, 1'b0);
        chk("R5 empty last-byte nxm", int'(r_nxm), 1);
        chk("R5 empty last-byte residual", int'(r_left), 0);
        chk("R5 empty last-byte stop", nreq, 8);
        fault_en = 1'b0;

        // R7 and R8 status record
        xstat_test(1'b0, 18'h3_0120);
        xstat_test(1'b1, 18'h0_03FC);
        preload();
        fault_en = 1'b1; fault_addr = 18'h1_0013;
        run(2'b10, 1'b0, 8'd9, 18'h1_0010, 1'b0);
        chk("R7 status fault nxm", int'(r_nxm), 1);
        chk("R7 status fault wc kept", int'(r_left), 9);
        chk("R5 status fault stop", nreq, 4);
        fault_en = 1'b0;

        // R10 no-transfer op
        run(2'b11, 1'b1, 8'd200, 18'h0_0000, 1'b0);
        chk("R10 no request", nreq, 0);
        chk("R10 no errors", int'(r_wco | r_nxm), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule